// File: doc/BRIEF.md
# Directory-Coherent Cache Line Controller

This block is the cache-side coherence engine for one processor in a shared-memory system that keeps coherence through a home directory rather than a snooped bus. It holds a small direct-mapped cache of one-word blocks. Each line carries a tag, a data word and a coherence state. The processor issues one load or store at a time and is held until that access completes. Hits complete locally. Misses are sent to the home directory as request messages, and the access finishes when the directory returns a data reply.

The home directory also sends three kinds of command to this cache: drop a shared copy, return an owned copy and keep it as shared, or return an owned copy and drop it. Two copies of the same data must never be writable at once. For that reason, when a miss lands on a line that owns a dirty block of another address, that block is written back before the new request goes out. The outbound message port carries one message per cycle, and an inbound directory command always takes it ahead of processor traffic.

Top module: `coh_cache_ctrl`

## Requirements
- R1: After reset every line is Invalid, cpu_ready_o and out_valid_o are low, and the first access to any address misses.
- R2: A load to an Invalid line puts a read-miss (out_type_o = 1) with the block address on the outbound port one cycle after the request is sampled. After the data reply, cpu_ready_o pulses with the replied word and the line becomes Shared.
- R3: A store to an Invalid line, or to a Shared line of the same address, sends a write-miss (out_type_o = 2). After the reply the line holds the store data in Exclusive state and cpu_rdata_o returns the stored word.
- R4: A load hit in Shared or Exclusive, and a store hit in Exclusive, raise cpu_ready_o one cycle after sampling and send no outbound message. A load returns the line's word.
- R5: An invalidate command (dir_msg_type_i = 1) for the address held Shared moves that line to Invalid, with no outbound message.
- R6: A fetch command (dir_msg_type_i = 2) for the address held Exclusive sends a write-back (out_type_o = 3) with that address and word on the next cycle and leaves the line Shared.
- R7: A fetch-and-invalidate command (dir_msg_type_i = 3) for the address held Exclusive sends a write-back with address and word and leaves the line Invalid.
- R8: A command whose address does not match the line's tag, or that meets a line not in the state it acts on, sends nothing and leaves the line unchanged.
- R9: A miss that lands on an Exclusive line of another address first sends a write-back of that victim (one cycle after sampling), then the read-miss or write-miss on the following free cycle. A Shared or Invalid victim is dropped without a message.
- R10: The processor is blocked until completion. cpu_ready_o is a one-cycle pulse that rises only when a hit is served or a reply is accepted: one cycle after sampling for a hit, and one cycle after the reply for a miss.
- R11: Directory commands are served first. A command in the same cycle as a processor request delays acceptance of the request by one cycle. A command write-back during a pending victim sequence delays the miss by one cycle. A command that arrives in the same cycle as the data reply is applied before the reply fills the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpu_req_i | input | 1 | Processor access request, held until cpu_ready_o |
| cpu_we_i | input | 1 | 1 = store, 0 = load |
| cpu_addr_i | input | ADDR_W | Block address of the access |
| cpu_wdata_i | input | DATA_W | Store data |
| cpu_ready_o | output | 1 | One-cycle completion pulse |
| cpu_rdata_o | output | DATA_W | Load result, or the stored word for a store |
| dir_msg_valid_i | input | 1 | Directory command present |
| dir_msg_type_i | input | 2 | 1 invalidate, 2 fetch, 3 fetch-and-invalidate |
| dir_msg_addr_i | input | ADDR_W | Address the command applies to |
| dir_reply_valid_i | input | 1 | Data reply for the outstanding miss |
| dir_reply_data_i | input | DATA_W | Reply word |
| out_valid_o | output | 1 | Outbound message valid for this cycle |
| out_type_o | output | 2 | 1 read-miss, 2 write-miss, 3 write-back |
| out_addr_o | output | ADDR_W | Address of the outbound message |
| out_data_o | output | DATA_W | Write-back word (zero on misses) |

## Verification
Every outbound message and every completion is registered. A hit completes one cycle after sampling. A plain miss completes two cycles after the request: the message appears after one cycle, the bench replies in that same cycle, and the pulse follows one cycle later. A victim write-back adds one cycle, and each directory command that takes the outbound port adds one more. The bench drives on falling edges, samples on falling edges, and counts falling edges from request to completion against these figures. A scoreboard holds the expected sequence of outbound messages and completions, so a missing, extra or reordered message shows up in the comparison.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [1:0] {
    LN_INV = 2'd0,
    LN_SHR = 2'd1,
    LN_EXC = 2'd2
  } line_st_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_SEND = 2'd1,
    S_WAIT = 2'd2
  } ctrl_st_e;

  localparam logic [1:0] DM_INV       = 2'd1;
  localparam logic [1:0] DM_FETCH     = 2'd2;
  localparam logic [1:0] DM_FETCH_INV = 2'd3;

  localparam logic [1:0] OUT_RD = 2'd1;
  localparam logic [1:0] OUT_WR = 2'd2;
  localparam logic [1:0] OUT_WB = 2'd3;
endpackage

// File: rtl/coh_line_array.sv
module coh_line_array
  import coh_pkg::*;
#(
  parameter int LINES  = 8,
  parameter int TAG_W  = 5,
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  ra_idx_i,
  output line_st_e          ra_st_o,
  output logic [TAG_W-1:0]  ra_tag_o,
  output logic [DATA_W-1:0] ra_data_o,
  input  logic [IDX_W-1:0]  rb_idx_i,
  output line_st_e          rb_st_o,
  output logic [TAG_W-1:0]  rb_tag_o,
  output logic [DATA_W-1:0] rb_data_o,
  // state-only port (directory commands)
  input  logic              wa_en_i,
  input  logic [IDX_W-1:0]  wa_idx_i,
  input  line_st_e          wa_st_i,
  // full-line port (fills, store hits, victims); wins over port a
  input  logic              wb_en_i,
  input  logic [IDX_W-1:0]  wb_idx_i,
  input  line_st_e          wb_st_i,
  input  logic [TAG_W-1:0]  wb_tag_i,
  input  logic [DATA_W-1:0] wb_data_i
);
  line_st_e          st_w   [LINES];
  logic [TAG_W-1:0]  tag_w  [LINES];
  logic [DATA_W-1:0] data_w [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    line_st_e          st_q;
    logic [TAG_W-1:0]  tag_q;
    logic [DATA_W-1:0] data_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_q   <= LN_INV;
        tag_q  <= '0;
        data_q <= '0;
      end else if (wb_en_i && wb_idx_i == IDX_W'(g)) begin
        st_q   <= wb_st_i;
        tag_q  <= wb_tag_i;
        data_q <= wb_data_i;
      end else if (wa_en_i && wa_idx_i == IDX_W'(g)) begin
        st_q <= wa_st_i;
      end
    end

    assign st_w[g]   = st_q;
    assign tag_w[g]  = tag_q;
    assign data_w[g] = data_q;
  end

  assign ra_st_o   = st_w[ra_idx_i];
  assign ra_tag_o  = tag_w[ra_idx_i];
  assign ra_data_o = data_w[ra_idx_i];
  assign rb_st_o   = st_w[rb_idx_i];
  assign rb_tag_o  = tag_w[rb_idx_i];
  assign rb_data_o = data_w[rb_idx_i];
endmodule

// File: rtl/coh_msg_eval.sv
module coh_msg_eval
  import coh_pkg::*;
#(
  parameter int TAG_W = 5
) (
  input  logic             valid_i,
  input  logic [1:0]       type_i,
  input  logic [TAG_W-1:0] msg_tag_i,
  input  line_st_e         line_st_i,
  input  logic [TAG_W-1:0] line_tag_i,
  output logic             upd_o,
  output line_st_e         new_st_o,
  output logic             wb_o
);
  logic match;
  assign match = valid_i && (line_tag_i == msg_tag_i);

  always_comb begin
    upd_o    = 1'b0;
    wb_o     = 1'b0;
    new_st_o = line_st_i;
    if (match) begin
      unique case (type_i)
        DM_INV: if (line_st_i == LN_SHR) begin
          upd_o    = 1'b1;
          new_st_o = LN_INV;
        end
        DM_FETCH: if (line_st_i == LN_EXC) begin
          upd_o    = 1'b1;
          wb_o     = 1'b1;
          new_st_o = LN_SHR;
        end
        DM_FETCH_INV: if (line_st_i == LN_EXC) begin
          upd_o    = 1'b1;
          wb_o     = 1'b1;
          new_st_o = LN_INV;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/coh_cache_ctrl.sv
module coh_cache_ctrl
  import coh_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int LINES  = 8,
  localparam int IDX_W = $clog2(LINES),
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_ready_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  input  logic              dir_msg_valid_i,
  input  logic [1:0]        dir_msg_type_i,
  input  logic [ADDR_W-1:0] dir_msg_addr_i,
  input  logic              dir_reply_valid_i,
  input  logic [DATA_W-1:0] dir_reply_data_i,
  output logic              out_valid_o,
  output logic [1:0]        out_type_o,
  output logic [ADDR_W-1:0] out_addr_o,
  output logic [DATA_W-1:0] out_data_o
);
  ctrl_st_e          st_q;
  logic              pend_we_q;
  logic [ADDR_W-1:0] pend_addr_q;
  logic [DATA_W-1:0] pend_wdata_q;

  logic [IDX_W-1:0]  c_idx, m_idx, p_idx;
  logic [TAG_W-1:0]  c_tag, m_tag, p_tag;
  line_st_e          c_st, m_st;
  logic [TAG_W-1:0]  c_ltag, m_ltag;
  logic [DATA_W-1:0] c_data, m_data;

  assign c_idx = cpu_addr_i[IDX_W-1:0];
  assign c_tag = cpu_addr_i[ADDR_W-1:IDX_W];
  assign m_idx = dir_msg_addr_i[IDX_W-1:0];
  assign m_tag = dir_msg_addr_i[ADDR_W-1:IDX_W];
  assign p_idx = pend_addr_q[IDX_W-1:0];
  assign p_tag = pend_addr_q[ADDR_W-1:IDX_W];

  logic              m_upd, m_wb;
  line_st_e          m_new_st;
  logic              wb_en;
  logic [IDX_W-1:0]  wb_idx;
  line_st_e          wb_st;
  logic [TAG_W-1:0]  wb_tag;
  logic [DATA_W-1:0] wb_data;

  coh_line_array #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_lines (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ra_idx_i  (c_idx),
    .ra_st_o   (c_st),
    .ra_tag_o  (c_ltag),
    .ra_data_o (c_data),
    .rb_idx_i  (m_idx),
    .rb_st_o   (m_st),
    .rb_tag_o  (m_ltag),
    .rb_data_o (m_data),
    .wa_en_i   (m_upd),
    .wa_idx_i  (m_idx),
    .wa_st_i   (m_new_st),
    .wb_en_i   (wb_en),
    .wb_idx_i  (wb_idx),
    .wb_st_i   (wb_st),
    .wb_tag_i  (wb_tag),
    .wb_data_i (wb_data)
  );

  coh_msg_eval #(.TAG_W(TAG_W)) u_eval (
    .valid_i    (dir_msg_valid_i),
    .type_i     (dir_msg_type_i),
    .msg_tag_i  (m_tag),
    .line_st_i  (m_st),
    .line_tag_i (m_ltag),
    .upd_o      (m_upd),
    .new_st_o   (m_new_st),
    .wb_o       (m_wb)
  );

  logic c_match, c_hit, c_victim, cpu_go, fill;
  assign c_match  = (c_ltag == c_tag);
  assign c_hit    = c_match && (cpu_we_i ? (c_st == LN_EXC) : (c_st != LN_INV));
  assign c_victim = (c_st == LN_EXC) && !c_match;
  // commands own the cycle; a completing access is not re-sampled
  assign cpu_go   = (st_q == S_IDLE) && cpu_req_i && !cpu_ready_o && !dir_msg_valid_i;
  assign fill     = (st_q == S_WAIT) && dir_reply_valid_i;

  always_comb begin
    wb_en   = 1'b0;
    wb_idx  = c_idx;
    wb_st   = LN_EXC;
    wb_tag  = c_tag;
    wb_data = cpu_wdata_i;
    if (cpu_go && c_hit && cpu_we_i) begin
      wb_en = 1'b1;
    end else if (cpu_go && !c_hit && c_victim) begin
      wb_en   = 1'b1;
      wb_st   = LN_INV;
      wb_tag  = c_ltag;
      wb_data = c_data;
    end else if (fill) begin
      wb_en   = 1'b1;
      wb_idx  = p_idx;
      wb_tag  = p_tag;
      wb_st   = pend_we_q ? LN_EXC : LN_SHR;
      wb_data = pend_we_q ? pend_wdata_q : dir_reply_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= S_IDLE;
      pend_we_q    <= 1'b0;
      pend_addr_q  <= '0;
      pend_wdata_q <= '0;
      cpu_ready_o  <= 1'b0;
      cpu_rdata_o  <= '0;
      out_valid_o  <= 1'b0;
      out_type_o   <= '0;
      out_addr_o   <= '0;
      out_data_o   <= '0;
    end else begin
      cpu_ready_o <= 1'b0;
      out_valid_o <= 1'b0;
      if (m_wb) begin
        out_valid_o <= 1'b1;
        out_type_o  <= OUT_WB;
        out_addr_o  <= dir_msg_addr_i;
        out_data_o  <= m_data;
      end
      unique case (st_q)
        S_IDLE: if (cpu_go) begin
          pend_we_q    <= cpu_we_i;
          pend_addr_q  <= cpu_addr_i;
          pend_wdata_q <= cpu_wdata_i;
          if (c_hit) begin
            cpu_ready_o <= 1'b1;
            cpu_rdata_o <= cpu_we_i ? cpu_wdata_i : c_data;
          end else if (c_victim) begin
            out_valid_o <= 1'b1;
            out_type_o  <= OUT_WB;
            out_addr_o  <= {c_ltag, c_idx};
            out_data_o  <= c_data;
            st_q        <= S_SEND;
          end else begin
            out_valid_o <= 1'b1;
            out_type_o  <= cpu_we_i ? OUT_WR : OUT_RD;
            out_addr_o  <= cpu_addr_i;
            out_data_o  <= '0;
            st_q        <= S_WAIT;
          end
        end
        S_SEND: if (!m_wb) begin
          out_valid_o <= 1'b1;
          out_type_o  <= pend_we_q ? OUT_WR : OUT_RD;
          out_addr_o  <= pend_addr_q;
          out_data_o  <= '0;
          st_q        <= S_WAIT;
        end
        S_WAIT: if (dir_reply_valid_i) begin
          cpu_ready_o <= 1'b1;
          cpu_rdata_o <= pend_we_q ? pend_wdata_q : dir_reply_data_i;
          st_q        <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  AST_HIT_LOCAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_go && c_hit |=> cpu_ready_o && !out_valid_o); // R4
  AST_MISS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_go && !c_hit && !c_victim |=> out_valid_o && out_type_o != OUT_WB && !cpu_ready_o); // R2
  AST_VICTIM_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_go && !c_hit && c_victim |=> out_valid_o && out_type_o == OUT_WB && !cpu_ready_o); // R9
  AST_CMD_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_wb |=> out_valid_o && out_type_o == OUT_WB && out_addr_o == $past(dir_msg_addr_i)); // R11
  AST_READY_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_ready_o |=> !cpu_ready_o); // R10
  AST_FILL_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill |=> cpu_ready_o); // R10
endmodule

// File: tb/tb_coh_cache_ctrl.sv
module tb_coh_cache_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] RD = 2'd1, WR = 2'd2, WB = 2'd3;
  localparam logic [1:0] C_INV = 2'd1, C_FET = 2'd2, C_FIN = 2'd3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_req = 0, cpu_we = 0;
  logic [7:0] cpu_addr = 0, cpu_wdata = 0;
  logic cpu_ready_o;
  logic [7:0] cpu_rdata_o;
  logic msg_valid = 0;
  logic [1:0] msg_type = 0;
  logic [7:0] msg_addr = 0;
  logic reply_valid = 0;
  logic [7:0] reply_data = 0;
  logic out_valid_o;
  logic [1:0] out_type_o;
  logic [7:0] out_addr_o, out_data_o;

  int tests = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  coh_cache_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata),
    .cpu_ready_o(cpu_ready_o), .cpu_rdata_o(cpu_rdata_o),
    .dir_msg_valid_i(msg_valid), .dir_msg_type_i(msg_type), .dir_msg_addr_i(msg_addr),
    .dir_reply_valid_i(reply_valid), .dir_reply_data_i(reply_data),
    .out_valid_o(out_valid_o), .out_type_o(out_type_o), .out_addr_o(out_addr_o),
    .out_data_o(out_data_o)
  );

  typedef struct { logic [1:0] typ; logic [7:0] addr; logic [7:0] data; string req; } out_item_t;
  typedef struct { logic [7:0] data; string req; } cpu_item_t;
  out_item_t out_q[$];
  cpu_item_t cpu_q[$];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic exp_out(input logic [1:0] t, input logic [7:0] a, input logic [7:0] d,
                         input string req);
    out_item_t it;
    it.typ = t; it.addr = a; it.data = d; it.req = req;
    out_q.push_back(it);
  endtask

  task automatic exp_cpu(input logic [7:0] d, input string req);
    cpu_item_t it;
    it.data = d; it.req = req;
    cpu_q.push_back(it);
  endtask

  // monitor: compare produced outputs against the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid_o) begin
        if (out_q.size() == 0)
          check(0, "R8", "unexpected message", {out_type_o, out_addr_o}, 0);
        else begin
          out_item_t it;
          it = out_q.pop_front();
          check(out_type_o == it.typ && out_addr_o == it.addr &&
                (it.typ != WB || out_data_o == it.data), it.req, "message",
                {out_type_o, out_addr_o, out_data_o}, {it.typ, it.addr, it.data});
        end
      end
      if (cpu_ready_o) begin
        if (cpu_q.size() == 0)
          check(0, "R10", "unexpected completion", cpu_rdata_o, 0);
        else begin
          cpu_item_t ct;
          ct = cpu_q.pop_front();
          check(cpu_rdata_o == ct.data, ct.req, "rdata", cpu_rdata_o, ct.data);
        end
      end
    end
  end

  // mode: 0 none, 1 command with request, 2 command with reply, 3 command one cycle after request
  task automatic cpu_op(input bit we, input logic [7:0] a, input logic [7:0] wd,
                        input logic [7:0] rep, input int lat, input int mode,
                        input logic [1:0] mt, input logic [7:0] ma, input string req);
    int k = 0;
    bit done = 0;
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    if (mode == 1) begin msg_valid = 1; msg_type = mt; msg_addr = ma; end
    while (!done && k < 40) begin
      @(negedge clk);
      k++;
      msg_valid = 0; reply_valid = 0;
      if (cpu_ready_o) done = 1;
      else begin
        if (mode == 3 && k == 1) begin msg_valid = 1; msg_type = mt; msg_addr = ma; end
        if (out_valid_o && out_type_o != WB) begin
          reply_valid = 1; reply_data = rep;
          if (mode == 2) begin msg_valid = 1; msg_type = mt; msg_addr = ma; end
        end
      end
    end
    cpu_req = 0;
    check(k == lat, {req, " R10"}, "latency", k, lat);
  endtask

  task automatic dir_cmd(input logic [1:0] t, input logic [7:0] a);
    @(negedge clk);
    msg_valid = 1; msg_type = t; msg_addr = a;
    @(negedge clk);
    msg_valid = 0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!out_valid_o && !cpu_ready_o, "R1", "idle after reset",
          {out_valid_o, cpu_ready_o}, 0);

    // R1/R2: cold read miss, then Shared read hit (R4)
    exp_out(RD, 8'h05, 0, "R1"); exp_cpu(8'hA5, "R2");
    cpu_op(0, 8'h05, 0, 8'hA5, 2, 0, 0, 0, "R2");
    exp_cpu(8'hA5, "R4");
    cpu_op(0, 8'h05, 0, 0, 1, 0, 0, 0, "R4");
    // R3: store to Shared upgrades through write-miss
    exp_out(WR, 8'h05, 0, "R3"); exp_cpu(8'h11, "R3");
    cpu_op(1, 8'h05, 8'h11, 8'hA5, 2, 0, 0, 0, "R3");
    exp_cpu(8'h22, "R4");
    cpu_op(1, 8'h05, 8'h22, 0, 1, 0, 0, 0, "R4");
    exp_cpu(8'h22, "R4");
    cpu_op(0, 8'h05, 0, 0, 1, 0, 0, 0, "R4");
    // R6: fetch, line left Shared
    exp_out(WB, 8'h05, 8'h22, "R6");
    dir_cmd(C_FET, 8'h05);
    exp_cpu(8'h22, "R6");
    cpu_op(0, 8'h05, 0, 0, 1, 0, 0, 0, "R6");
    exp_out(WR, 8'h05, 0, "R6"); exp_cpu(8'h33, "R6");
    cpu_op(1, 8'h05, 8'h33, 8'h00, 2, 0, 0, 0, "R6");
    // R7: fetch-and-invalidate
    exp_out(WB, 8'h05, 8'h33, "R7");
    dir_cmd(C_FIN, 8'h05);
    exp_out(RD, 8'h05, 0, "R7"); exp_cpu(8'h44, "R7");
    cpu_op(0, 8'h05, 0, 8'h44, 2, 0, 0, 0, "R7");
    // R5: invalidate Shared
    dir_cmd(C_INV, 8'h05);
    exp_out(RD, 8'h05, 0, "R5"); exp_cpu(8'h55, "R5");
    cpu_op(0, 8'h05, 0, 8'h55, 2, 0, 0, 0, "R5");
    // R8: commands with no effect
    dir_cmd(C_FET, 8'h05);
    exp_cpu(8'h55, "R8");
    cpu_op(0, 8'h05, 0, 0, 1, 0, 0, 0, "R8");
    dir_cmd(C_FIN, 8'h0D);
    dir_cmd(C_INV, 8'h0D);
    exp_cpu(8'h55, "R8");
    cpu_op(0, 8'h05, 0, 0, 1, 0, 0, 0, "R8");
    // R9: Shared victim dropped silently, Exclusive victim written back
    exp_out(RD, 8'h0D, 0, "R9"); exp_cpu(8'h66, "R9");
    cpu_op(0, 8'h0D, 0, 8'h66, 2, 0, 0, 0, "R9");
    exp_out(WR, 8'h0D, 0, "R9"); exp_cpu(8'h77, "R9");
    cpu_op(1, 8'h0D, 8'h77, 8'h66, 2, 0, 0, 0, "R9");
    exp_out(WB, 8'h0D, 8'h77, "R9"); exp_out(RD, 8'h05, 0, "R9"); exp_cpu(8'h88, "R9");
    cpu_op(0, 8'h05, 0, 8'h88, 3, 0, 0, 0, "R9");
    // R11: command alongside a request
    exp_out(WR, 8'h10, 0, "R11"); exp_cpu(8'h99, "R11");
    cpu_op(1, 8'h10, 8'h99, 0, 2, 0, 0, 0, "R11");
    exp_out(WB, 8'h10, 8'h99, "R11"); exp_out(RD, 8'h21, 0, "R11"); exp_cpu(8'hBB, "R11");
    cpu_op(0, 8'h21, 0, 8'hBB, 3, 1, C_FET, 8'h10, "R11");
    // R11: invalidate alongside the reply, reply wins
    exp_out(WR, 8'h21, 0, "R11"); exp_cpu(8'hCC, "R11");
    cpu_op(1, 8'h21, 8'hCC, 8'h00, 2, 2, C_INV, 8'h21, "R11");
    exp_cpu(8'hCD, "R11");
    cpu_op(1, 8'h21, 8'hCD, 0, 1, 0, 0, 0, "R11");
    // R11: command write-back inside a victim sequence
    exp_out(WR, 8'h03, 0, "R11"); exp_cpu(8'h31, "R11");
    cpu_op(1, 8'h03, 8'h31, 0, 2, 0, 0, 0, "R11");
    exp_out(WR, 8'h04, 0, "R11"); exp_cpu(8'h41, "R11");
    cpu_op(1, 8'h04, 8'h41, 0, 2, 0, 0, 0, "R11");
    exp_out(WB, 8'h03, 8'h31, "R9"); exp_out(WB, 8'h04, 8'h41, "R11");
    exp_out(RD, 8'h13, 0, "R11"); exp_cpu(8'hDD, "R11");
    cpu_op(0, 8'h13, 0, 8'hDD, 4, 3, C_FIN, 8'h04, "R11");
    exp_out(RD, 8'h04, 0, "R7"); exp_cpu(8'h42, "R7");
    cpu_op(0, 8'h04, 0, 8'h42, 2, 0, 0, 0, "R7");

    repeat (3) @(negedge clk);
    check(out_q.size() == 0 && cpu_q.size() == 0, "R10", "scoreboard drained",
          out_q.size() + cpu_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule